// File: doc/BRIEF.md
# Sound Generator Register Write Decoder

This block sits between a host byte bus and the register file of a four-channel sound generator. The generator has three tone voices and one noise voice. Every voice has a 4-bit attenuation register. Each tone voice also has a 10-bit half-period register, and the noise voice has a 3-bit control register. The host writes one byte per cycle on a single-cycle strobe. A byte with its top bit set, called a select byte, chooses a target register and loads its low nibble. A byte with its top bit clear, called a continuation byte, adds payload to whichever register was chosen last. How that payload is merged depends on the width of the target register.

All register contents are available as parallel outputs for the tone counters, the noise generator and the attenuators downstream. Each write to the noise control register also produces a one-cycle reseed pulse for the noise shift register.

Top module: `sndreg_decoder`

## Requirements
- R1: After reset, all four attenuation registers read 4'hF, all tone periods and the noise control read zero, and the stored target is voice 0 period.
- R2: A select byte has bit 7 = 1. Bits 6:5 name the voice (0..3, where 3 is noise), bit 4 picks attenuation (1) or period/noise control (0), and bits 3:0 are loaded into bits 3:0 of that register on the clock edge that samples the strobe.
- R3: A select byte to a tone period changes bits 3:0 only, and bits 9:4 keep their value.
- R4: A select byte to the noise control stores bits 2:0 of the byte and drops bit 3.
- R5: A continuation byte has bit 7 = 0 and bit 6 is ignored. When the stored target is a tone period, payload bits 5:0 go into period bits 9:4 and bits 3:0 are unchanged.
- R6: A continuation byte aimed at an attenuation register writes payload bits 3:0 into it. One aimed at the noise control writes payload bits 2:0 into it. Higher payload bits are dropped.
- R7: A continuation byte never changes the stored target, so consecutive continuation bytes all reach the same register.
- R8: Each write to the noise control, whether by a select byte or a continuation byte, raises `noise_reseed` for exactly the one cycle after the write edge. Otherwise it stays low.
- R9: Noise control bits 1:0 are presented as `noise_rate` and bit 2 as `noise_white` (1 = white, 0 = periodic).
- R10: When the strobe is low, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_data | input | 8 | Written byte |
| tone_period | output | 30 | Tone voice periods, voice k in bits 10k+9:10k |
| atten | output | 16 | Attenuation, voice k in bits 4k+3:4k |
| noise_rate | output | 2 | Noise shift rate select |
| noise_white | output | 1 | Noise mode, 1 = white |
| noise_reseed | output | 1 | One-cycle pulse after each noise control write |

## Verification
The stored target pointer cannot be seen at the ports, so a wrong pointer only shows up on the next continuation byte. That byte lands in the wrong register, or in the wrong half of a period, and the damage is visible one cycle after the strobe. For this reason every scenario follows a select byte with one or more continuation bytes and then reads back all outputs. Width-merge faults show up as changed high or low period bits, or as leaked high payload bits, in that same cycle.

// File: rtl/sndreg_pkg.sv
package sndreg_pkg;
   localparam int unsigned NUM_VOICES  = 4;
   localparam int unsigned TONE_VOICES = NUM_VOICES - 1;
   localparam int unsigned PERIOD_W    = 10;
   localparam int unsigned ATTEN_W     = 4;
   localparam int unsigned NCTRL_W     = 3;
   localparam int unsigned VSEL_W      = $clog2(NUM_VOICES);

   typedef struct packed {
      logic [VSEL_W-1:0] voice;
      logic              is_atten;
   } target_t;

   typedef struct packed {
      logic              wr;
      logic              is_select;
      target_t           tgt;
      logic [5:0]        payload;
   } wr_cmd_t;
endpackage

// File: rtl/sndreg_parse.sv
module sndreg_parse
   import sndreg_pkg::*;
(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [7:0]    wr_data,
   output wr_cmd_t       cmd
);
   target_t cur_q;
   logic    sel;

   assign sel = wr_data[7];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cur_q <= '0;
      else if (wr_en && sel)   cur_q <= target_t'({wr_data[6:5], wr_data[4]});
   end

   always_comb begin
      cmd.wr        = wr_en;
      cmd.is_select = sel;
      cmd.tgt       = sel ? target_t'({wr_data[6:5], wr_data[4]}) : cur_q;
      cmd.payload   = sel ? {2'b00, wr_data[3:0]} : wr_data[5:0];
   end

   // R7: a continuation byte leaves the stored target as it was
   assert_hold_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_data[7]) |=> $stable(cur_q));
endmodule

// File: rtl/sndreg_field.sv
module sndreg_field
   import sndreg_pkg::*;
#(
   parameter int unsigned WIDTH     = 4,
   parameter logic [WIDTH-1:0] RST_VAL = '0
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit,
   input  logic             is_select,
   input  logic [5:0]       payload,
   output logic [WIDTH-1:0] value
);
   initial begin
      assert (WIDTH >= 1 && WIDTH <= 16) else $error("sndreg_field: WIDTH out of range");
   end

   logic [WIDTH-1:0] nxt;

   generate
      if (WIDTH > 6) begin : g_wide
         always_comb begin
            nxt = value;
            if (is_select) nxt[3:0] = payload[3:0];
            else           nxt[WIDTH-1:4] = payload[WIDTH-5:0];
         end
      end else begin : g_narrow
         localparam int unsigned SELW = (WIDTH < 4) ? WIDTH : 4;
         always_comb begin
            nxt = value;
            if (is_select) nxt[SELW-1:0] = payload[SELW-1:0];
            else           nxt = payload[WIDTH-1:0];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   value <= RST_VAL;
      else if (hit) value <= nxt;
   end

   // R10: the field holds when not addressed
   assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> $stable(value));
endmodule

// File: rtl/sndreg_decoder.sv
module sndreg_decoder
   import sndreg_pkg::*;
#(
   parameter int unsigned N_VOICES = 4,
   parameter int unsigned P_W      = 10,
   parameter int unsigned A_W      = 4
)(
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [7:0]                    wr_data,
   output logic [(N_VOICES-1)*P_W-1:0]   tone_period,
   output logic [N_VOICES*A_W-1:0]       atten,
   output logic [1:0]                    noise_rate,
   output logic                          noise_white,
   output logic                          noise_reseed
);
   localparam int unsigned NT = N_VOICES - 1;

   initial begin
      assert (N_VOICES == NUM_VOICES) else $error("sndreg_decoder: voice count fixed by byte format");
      assert (P_W == 10) else $error("sndreg_decoder: period width must be 10");
      assert (A_W == 4) else $error("sndreg_decoder: attenuation width must be 4");
   end

   wr_cmd_t cmd;
   logic [NCTRL_W-1:0] nctrl;
   logic noise_hit;

   sndreg_parse u_parse (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .cmd(cmd));

   genvar v;
   generate
      for (v = 0; v < N_VOICES; v++) begin : g_voice
         sndreg_field #(.WIDTH(A_W), .RST_VAL({A_W{1'b1}})) u_att (
            .clk(clk), .rst_n(rst_n),
            .hit(cmd.wr && cmd.tgt.is_atten && cmd.tgt.voice == VSEL_W'(v)),
            .is_select(cmd.is_select), .payload(cmd.payload),
            .value(atten[v*A_W +: A_W]));
         if (v < NT) begin : g_tone
            sndreg_field #(.WIDTH(P_W), .RST_VAL('0)) u_per (
               .clk(clk), .rst_n(rst_n),
               .hit(cmd.wr && !cmd.tgt.is_atten && cmd.tgt.voice == VSEL_W'(v)),
               .is_select(cmd.is_select), .payload(cmd.payload),
               .value(tone_period[v*P_W +: P_W]));
         end
      end
   endgenerate

   assign noise_hit = cmd.wr && !cmd.tgt.is_atten && cmd.tgt.voice == VSEL_W'(NT);

   sndreg_field #(.WIDTH(NCTRL_W), .RST_VAL('0)) u_noise (
      .clk(clk), .rst_n(rst_n), .hit(noise_hit),
      .is_select(cmd.is_select), .payload(cmd.payload), .value(nctrl));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) noise_reseed <= 1'b0;
      else        noise_reseed <= noise_hit;
   end

   assign noise_rate  = nctrl[1:0];
   assign noise_white = nctrl[2];

   // R8: reseed follows a noise-targeted select byte
   assert_reseed_sel_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[7:4] == 4'b1110) |=> noise_reseed);
   // R8: reseed is a single-cycle pulse unless written back to back
   assert_reseed_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> !noise_reseed);
   // R10: nothing changes without a strobe
   assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(tone_period) && $stable(atten) && $stable(noise_rate) && $stable(noise_white)));
   // R3: a select byte to voice 0 period keeps its upper bits
   assert_keep_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[7:4] == 4'b1000) |=> $stable(tone_period[P_W-1:4]));
endmodule

// File: tb/sndreg_decoder_bench.sv
module sndreg_decoder_bench;
   localparam time CLK_PERIOD = 10ns;

   logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [29:0] tone_period;
   logic [15:0] atten;
   logic [1:0] noise_rate;
   logic noise_white, noise_reseed;

   int checks = 0, fails = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sndreg_decoder u_sndreg_decoder (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .tone_period(tone_period), .atten(atten), .noise_rate(noise_rate),
      .noise_white(noise_white), .noise_reseed(noise_reseed));

   logic [9:0] ep [3];
   logic [3:0] ea [4];
   logic [2:0] en;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_all(input string req);
      for (int i = 0; i < 3; i++) chk(req, 32'(tone_period[i*10 +: 10]), 32'(ep[i]));
      for (int i = 0; i < 4; i++) chk(req, 32'(atten[i*4 +: 4]), 32'(ea[i]));
      chk(req, {30'd0, noise_rate}, {30'd0, en[1:0]});
      chk(req, {31'd0, noise_white}, {31'd0, en[2]});
   endtask

   // drive one byte; return after the edge, sampling mid-cycle
   task automatic wr(input logic [7:0] b);
      @(negedge clk); wr_en = 1'b1; wr_data = b;
      @(negedge clk); wr_en = 1'b0; wr_data = 8'h00;
   endtask

   task automatic t_reset;
      for (int i = 0; i < 3; i++) ep[i] = '0;
      for (int i = 0; i < 4; i++) ea[i] = 4'hF;
      en = '0;
      check_all("R1");
      chk("R1", {31'd0, noise_reseed}, 32'd0);
      wr(8'h15); ep[0][9:4] = 6'h15; check_all("R1 target voice0 period");
   endtask

   task automatic t_select;
      wr(8'hA7); ep[1][3:0] = 4'h7; check_all("R2");
      wr(8'hD3); ea[2] = 4'h3; check_all("R2");
      wr(8'h3F); ea[2] = 4'hF; check_all("R6 atten drop high");
      wr(8'h65); ea[2] = 4'h5; check_all("R6 bit6 ignored R5");
      wr(8'h8C); ep[0][3:0] = 4'hC; check_all("R3");
   endtask

   task automatic t_tone_cont;
      wr(8'hC9); ep[2][3:0] = 4'h9; check_all("R2");
      wr(8'h2A); ep[2][9:4] = 6'h2A; check_all("R5");
      wr(8'h41); ep[2][9:4] = 6'h01; check_all("R5 bit6 ignored");
      wr(8'h3E); ep[2][9:4] = 6'h3E; check_all("R7 repeated");
   endtask

   task automatic t_noise;
      wr(8'hED); en = 3'b101;
      chk("R8 pulse", {31'd0, noise_reseed}, 32'd1);
      check_all("R4"); chk("R9", {30'd0, noise_rate}, 32'd1);
      chk("R9 white", {31'd0, noise_white}, 32'd1);
      @(negedge clk); chk("R8 single", {31'd0, noise_reseed}, 32'd0);
      wr(8'h3A); en = 3'b010;
      chk("R8 cont pulse", {31'd0, noise_reseed}, 32'd1);
      check_all("R6 noise");
      wr(8'hF8); ea[3] = 4'h8;
      chk("R8 no pulse atten", {31'd0, noise_reseed}, 32'd0);
      check_all("R2");
   endtask

   task automatic t_idle;
      @(negedge clk); wr_data = 8'h80;
      @(negedge clk); wr_data = 8'h3F;
      @(negedge clk); wr_data = 8'h00;
      check_all("R10");
      wr(8'h01); ea[3] = 4'h1; check_all("R10 R7 target kept");
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            t_reset; t_select; t_tone_cont; t_noise; t_idle;
         end
         begin
            repeat (5000) @(posedge clk);
            checks++; fails++;
            $display("FAIL watchdog expired");
         end
      join_any
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule